// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block sits on the controller side of a DDR SDRAM interface and takes the memory from power-up to normal operation. Every command it issues is one packed 18-bit word. The top three bits carry the row strobe, column strobe and write-enable pins at their raw active-low levels. Below them sit the bank address and the row/column address. A pulse on `start` first holds the memory disabled through a power-up settling wait of 100 µs. The block then steps through a fixed bring-up order:

- close all banks
- program the extended mode register
- program the mode register with DLL reset set
- issue two auto-refresh commands
- program the mode register again with DLL reset cleared

Between consecutive commands it waits a programmable number of clock cycles.

After the last wait, the block raises memory enable, periodic refresh enable and the initialization-complete status, all in the same cycle. A reset request drops all three at once and aborts any sequence in progress. Host software can also place single command words on the memory pins through a valid/ready port. A manual word is held off while the sequencer is busy.

Top module: `ddr_init_seq`

## Requirements
- R1: After `rst_n` is released, and before any `start`, the block is idle. `cmd_word` is the idle word 0x38000, `mem_en`, `refresh_en`, `init_done` and `busy` are low, and `man_ready` is high.
- R2: Command word layout: bit 17 is row strobe, bit 16 is column strobe and bit 15 is write enable, all active low. Bits 14:13 are the bank address and bits 12:0 are the address. In every cycle without a command, the word is 0x38000.
- R3: A `start` accepted on a clock edge keeps `mem_en` and `refresh_en` low and issues no command for 100*CLK_MHZ cycles. The first command then appears exactly that many cycles after the accepting edge.
- R4: The sequence consists of exactly these six words, each on `cmd_word` for one cycle: 0x17FFF (close all banks, address bit 10 high), 0x02002 (extended mode: DLL enabled, reduced drive), 0x00163 (burst 8, CAS latency 2.5, DLL reset), 0x08000, 0x08000 (auto-refresh twice) and 0x00063 (DLL reset cleared).
- R5: Consecutive sequence commands are spaced by the gap `gap_cycles` sampled at `start`. A value of 0 selects CLK_MHZ cycles (1 µs), and a value of 1 is raised to 2.
- R6: One gap after the last command, `init_done`, `mem_en` and `refresh_en` rise together and `busy` falls. They rise in no earlier cycle.
- R7: `init_reset` aborts any sequence. After the next edge, `init_done`, `mem_en`, `refresh_en` and `busy` are low and `cmd_word` is 0x38000.
- R8: When `man_valid` and `man_ready` are both high on an edge, `man_cmd` is on `cmd_word` for the following cycle.
- R9: `man_ready` is low while `busy` is high. A manual word held valid through a sequence is not issued during it, and it appears in the cycle after `init_done` rises.
- R10: A `start` pulse while `busy` is high is ignored. The command order and timing of the running sequence are unchanged.
- R11: A manual command does not change `init_done`, `mem_en` or `refresh_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the bring-up sequence (taken only while idle) |
| init_reset | input | 1 | Disable memory, clear status, abort the sequence |
| gap_cycles | input | GAP_W | Cycles between commands; 0 selects 1 µs |
| man_valid | input | 1 | Host offers a manual command word |
| man_cmd | input | 18 | Manual command word |
| man_ready | output | 1 | Manual word accepted this edge when valid |
| cmd_word | output | 18 | Packed command pins for the memory |
| busy | output | 1 | Bring-up sequence in progress |
| mem_en | output | 1 | Memory enabled for normal operation |
| refresh_en | output | 1 | Periodic auto-refresh request enabled |
| init_done | output | 1 | Initialization complete status |

## Verification
The hardest situations to reach from the ports are the collisions with a running sequence. One is a manual word that has been waiting since before `start` and must come out in exactly the cycle after completion. The other is a second `start` landing mid-gap. The stimulus reaches both by holding `man_valid` from the `start` cycle, and by pulsing `start` again halfway through the first gap, within runs whose gaps are drawn at random. Those gaps include the 0 and 1 values that are remapped. The abort case is reached by raising `init_reset` at a random point inside a gap.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
   localparam int CW      = 18;
   localparam int RAS_BIT = 17;
   localparam int CAS_BIT = 16;
   localparam int WE_BIT  = 15;
   localparam int BA_LO   = 13;
   localparam int AW      = 13;
   localparam int NSTEPS  = 6;
   localparam int IDX_W   = 3;

   typedef logic [CW-1:0] cmdw_t;

   localparam cmdw_t CMD_IDLE = 18'h38000;

   typedef enum logic [1:0] {ST_OFF, ST_PWR, ST_GAP, ST_ON} seq_st_t;

   function automatic cmdw_t pack_cmd(input logic ras_n, input logic cas_n,
                                      input logic we_n, input logic [1:0] ba,
                                      input logic [AW-1:0] a);
      cmdw_t w;
      w            = '0;
      w[RAS_BIT]   = ras_n;
      w[CAS_BIT]   = cas_n;
      w[WE_BIT]    = we_n;
      w[BA_LO+:2]  = ba;
      w[AW-1:0]    = a;
      return w;
   endfunction
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] value,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= value;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
   import ddr_init_pkg::*;
#(
   parameter bit       REDUCED_DRIVE = 1'b1,
   parameter bit [2:0] BURST_CODE    = 3'd3,
   parameter bit [2:0] CAS_CODE      = 3'd6
) (
   input  logic [IDX_W-1:0] idx,
   output cmdw_t            word
);
   localparam logic [AW-1:0] MR_BASE =
      {4'b0, 1'b0, 1'b0, CAS_CODE, 1'b0, BURST_CODE};
   localparam logic [AW-1:0] MR_DLLRST = MR_BASE | 13'h100;

   logic [AW-1:0] emr_val;

   generate
      if (REDUCED_DRIVE) begin : g_drv_reduced
         assign emr_val = 13'h002;
      end else begin : g_drv_full
         assign emr_val = 13'h000;
      end
   endgenerate

   always_comb begin
      unique case (idx)
         3'd0:    word = pack_cmd(1'b0, 1'b1, 1'b0, 2'b11, {AW{1'b1}});
         3'd1:    word = pack_cmd(1'b0, 1'b0, 1'b0, 2'b01, emr_val);
         3'd2:    word = pack_cmd(1'b0, 1'b0, 1'b0, 2'b00, MR_DLLRST);
         3'd3,
         3'd4:    word = pack_cmd(1'b0, 1'b0, 1'b1, 2'b00, '0);
         3'd5:    word = pack_cmd(1'b0, 1'b0, 1'b0, 2'b00, MR_BASE);
         default: word = CMD_IDLE;
      endcase
   end
endmodule

// File: rtl/ddr_init_cmd_out.sv
module ddr_init_cmd_out
   import ddr_init_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  seq_fire,
   input  cmdw_t seq_word,
   input  logic  man_fire,
   input  cmdw_t man_word,
   output cmdw_t cmd_word
);
   cmdw_t nxt;

   always_comb begin
      if (seq_fire)      nxt = seq_word;
      else if (man_fire) nxt = man_word;
      else               nxt = CMD_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_word <= CMD_IDLE;
      else        cmd_word <= nxt;
   end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int       CLK_MHZ       = 125,
   parameter int       PWRUP_US      = 100,
   parameter int       GAP_W         = 16,
   parameter bit       REDUCED_DRIVE = 1'b1,
   parameter bit [2:0] BURST_CODE    = 3'd3,
   parameter bit [2:0] CAS_CODE      = 3'd6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             init_reset,
   input  logic [GAP_W-1:0] gap_cycles,
   input  logic             man_valid,
   input  logic [17:0]      man_cmd,
   output logic             man_ready,
   output logic [17:0]      cmd_word,
   output logic             busy,
   output logic             mem_en,
   output logic             refresh_en,
   output logic             init_done
);
   localparam int PWR_CYC = PWRUP_US * CLK_MHZ;
   localparam int PWR_W   = $clog2(PWR_CYC + 1);
   localparam int TW      = ((PWR_W > GAP_W) ? PWR_W : GAP_W) + 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NSTEPS - 1);

   generate
      if (CLK_MHZ < 2) begin : g_bad_clk
         $error("CLK_MHZ must be at least 2");
      end
      if (GAP_W < $clog2(CLK_MHZ + 1)) begin : g_bad_gap
         $error("GAP_W too narrow for the default gap");
      end
   endgenerate

   seq_st_t          st_q;
   logic [IDX_W-1:0] idx_q, fire_idx;
   logic [GAP_W-1:0] gap_q, gap_eff;
   logic             on_q, idle, start_go, seq_fire, man_fire, tmr_load, expired;
   logic [TW-1:0]    tmr_val;
   cmdw_t            step_word;

   assign idle      = (st_q == ST_OFF) || (st_q == ST_ON);
   assign start_go  = start && idle && !init_reset;
   assign man_ready = idle && !start && !init_reset;
   assign man_fire  = man_valid && man_ready;

   always_comb begin
      if (gap_cycles == '0)      gap_eff = GAP_W'(CLK_MHZ);
      else if (gap_cycles < 2)   gap_eff = GAP_W'(2);
      else                       gap_eff = gap_cycles;
   end

   always_comb begin
      seq_fire = 1'b0;
      fire_idx = '0;
      if (!init_reset && expired) begin
         if (st_q == ST_PWR) begin
            seq_fire = 1'b1;
         end else if (st_q == ST_GAP && idx_q != LAST) begin
            seq_fire = 1'b1;
            fire_idx = idx_q + 1'b1;
         end
      end
   end

   assign tmr_load = start_go || seq_fire;
   assign tmr_val  = start_go ? TW'(PWR_CYC - 1) : TW'(gap_q) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_OFF;
         idx_q <= '0;
         gap_q <= GAP_W'(2);
         on_q  <= 1'b0;
      end else if (init_reset) begin
         st_q  <= ST_OFF;
         on_q  <= 1'b0;
      end else if (start_go) begin
         st_q  <= ST_PWR;
         gap_q <= gap_eff;
         on_q  <= 1'b0;
      end else if (seq_fire) begin
         st_q  <= ST_GAP;
         idx_q <= fire_idx;
      end else if (st_q == ST_GAP && expired) begin
         st_q  <= ST_ON;
         on_q  <= 1'b1;
      end
   end

   assign busy       = !idle;
   assign mem_en     = on_q;
   assign refresh_en = on_q;
   assign init_done  = on_q;

   ddr_init_timer #(.W(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .value   (tmr_val),
      .expired (expired)
   );

   ddr_init_steps #(
      .REDUCED_DRIVE (REDUCED_DRIVE),
      .BURST_CODE    (BURST_CODE),
      .CAS_CODE      (CAS_CODE)
   ) u_steps (
      .idx  (fire_idx),
      .word (step_word)
   );

   ddr_init_cmd_out u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .seq_fire (seq_fire),
      .seq_word (step_word),
      .man_fire (man_fire),
      .man_word (man_cmd),
      .cmd_word (cmd_word)
   );
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        init_reset,
   input logic        man_valid,
   input logic [17:0] man_cmd,
   input logic        man_ready,
   input logic [17:0] cmd_word,
   input logic        busy,
   input logic        mem_en,
   input logic        refresh_en,
   input logic        init_done
);
   localparam logic [17:0] IDLE_W = 18'h38000;

   p_disabled_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!mem_en && !refresh_en));

   p_one_cycle_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_word != IDLE_W) |=> (cmd_word == IDLE_W));

   p_done_after_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(busy));

   p_abort_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      init_reset |=> (!init_done && !mem_en && !busy && cmd_word == IDLE_W));

   p_manual_echo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (man_valid && man_ready) |=> (cmd_word == $past(man_cmd)));

   p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !man_ready);

   p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !init_reset) |=> busy);

   p_manual_keeps_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (man_valid && man_ready && !start && !init_reset) |=> $stable(init_done));
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .init_reset (init_reset),
   .man_valid  (man_valid),
   .man_cmd    (man_cmd),
   .man_ready  (man_ready),
   .cmd_word   (cmd_word),
   .busy       (busy),
   .mem_en     (mem_en),
   .refresh_en (refresh_en),
   .init_done  (init_done)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
   localparam int CLK_MHZ = 125;
   localparam int PWR     = 100 * CLK_MHZ;
   localparam int GAP_W   = 16;
   localparam logic [17:0] IDLE_W = 18'h38000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             init_reset = 1'b0;
   logic [GAP_W-1:0] gap_cycles = '0;
   logic             man_valid = 1'b0;
   logic [17:0]      man_cmd = '0;
   logic             man_ready, busy, mem_en, refresh_en, init_done;
   logic [17:0]      cmd_word;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ddr_init_seq #(.CLK_MHZ(CLK_MHZ), .GAP_W(GAP_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .init_reset(init_reset),
      .gap_cycles(gap_cycles), .man_valid(man_valid), .man_cmd(man_cmd),
      .man_ready(man_ready), .cmd_word(cmd_word), .busy(busy),
      .mem_en(mem_en), .refresh_en(refresh_en), .init_done(init_done)
   );

   function automatic logic [17:0] mk(input logic r, input logic c, input logic w,
                                      input logic [1:0] ba, input logic [12:0] a);
      return {r, c, w, ba, a};
   endfunction

   function automatic logic [17:0] exp_word(input int i);
      case (i)
         0: return mk(1'b0, 1'b1, 1'b0, 2'b11, 13'h1FFF);
         1: return mk(1'b0, 1'b0, 1'b0, 2'b01, 13'h0002);
         2: return mk(1'b0, 1'b0, 1'b0, 2'b00, 13'h0163);
         3, 4: return mk(1'b0, 1'b0, 1'b1, 2'b00, 13'h0000);
         default: return mk(1'b0, 1'b0, 1'b0, 2'b00, 13'h0063);
      endcase
   endfunction

   function automatic int eff_gap(input int g);
      if (g == 0) return CLK_MHZ;
      if (g < 2)  return 2;
      return g;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic run_init(input int gcfg, input bit hold_man,
                           input logic [17:0] mval, input bit restart);
      int g, last, n, bad_en, bad_rdy;
      int pos[6];
      logic [17:0] wd[6];
      bit prev_done;
      g = eff_gap(gcfg);
      last = PWR + 6 * g + 1;
      n = 0; bad_en = 0; bad_rdy = 0; prev_done = 1'b0;
      @(negedge clk);
      gap_cycles = GAP_W'(gcfg);
      start = 1'b1;
      if (hold_man) begin man_valid = 1'b1; man_cmd = mval; end
      @(negedge clk);
      start = 1'b0;
      for (int k = 1; k <= last; k++) begin
         if (k < last) begin
            if (busy && man_ready) bad_rdy++;
            if (mem_en || refresh_en) bad_en++;
            prev_done = init_done;
         end
         if (cmd_word != IDLE_W && k < last) begin
            if (n < 6) begin pos[n] = k; wd[n] = cmd_word; end
            n++;
         end
         if (k == last) break;
         start = (restart && k == PWR + 1 + g / 2);
         @(negedge clk);
      end
      start = 1'b0;
      check(n == 6, "R4 command count", n, 6);
      check(bad_en == 0, "R3 memory disabled while busy", bad_en, 0);
      check(bad_rdy == 0, "R9 man_ready low while busy", bad_rdy, 0);
      if (n >= 6) begin
         check(pos[0] == PWR + 1, "R3 first command delay", pos[0], PWR + 1);
         for (int i = 0; i < 6; i++) begin
            check(wd[i] == exp_word(i), "R4 command word", wd[i], exp_word(i));
            if (i > 0)
               check(pos[i] - pos[i-1] == g,
                     restart ? "R10 spacing after ignored start" : "R5 command spacing",
                     pos[i] - pos[i-1], g);
         end
      end
      check(!prev_done, "R6 done not early", prev_done, 0);
      check(init_done && mem_en && refresh_en && !busy, "R6 completion flags",
            {init_done, mem_en, refresh_en, busy}, 4'b1110);
      if (hold_man) begin
         @(negedge clk);
         check(cmd_word == mval, "R9 held manual issued after done", cmd_word, mval);
         man_valid = 1'b0;
         @(negedge clk);
         check(cmd_word == IDLE_W, "R2 idle word after manual", cmd_word, IDLE_W);
      end
   endtask

   task automatic manual_burst(input int cnt);
      logic [17:0] v;
      bit d0;
      for (int i = 0; i < cnt; i++) begin
         @(negedge clk);
         v = 18'($urandom());
         d0 = init_done;
         man_valid = 1'b1; man_cmd = v;
         check(man_ready, "R8 ready while idle", man_ready, 1);
         @(negedge clk);
         man_valid = 1'b0;
         check(cmd_word == v, "R8 manual echo", cmd_word, v);
         check(init_done == d0 && mem_en == d0, "R11 flags unchanged", init_done, d0);
      end
      @(negedge clk);
      check(cmd_word == IDLE_W, "R2 idle word", cmd_word, IDLE_W);
   endtask

   task automatic abort_test(input int gcfg);
      int g, wait_n;
      g = eff_gap(gcfg);
      @(negedge clk);
      gap_cycles = GAP_W'(gcfg);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_n = PWR + 2 * g + int'($urandom_range(1, g - 1));
      repeat (wait_n) @(negedge clk);
      check(busy, "R7 busy before abort", busy, 1);
      init_reset = 1'b1;
      @(negedge clk);
      init_reset = 1'b0;
      check(!init_done && !mem_en && !refresh_en && !busy && cmd_word == IDLE_W,
            "R7 abort clears", {init_done, mem_en, refresh_en, busy}, 0);
      repeat (3 * g) begin
         @(negedge clk);
         if (cmd_word != IDLE_W || busy) begin
            check(1'b0, "R7 no command after abort", cmd_word, IDLE_W);
            break;
         end
      end
      check(!init_done, "R7 stays off", init_done, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_word == IDLE_W, "R1 reset idle word", cmd_word, IDLE_W);
      check(!mem_en && !refresh_en && !init_done && !busy, "R1 reset flags",
            {mem_en, refresh_en, init_done, busy}, 0);
      check(man_ready, "R1 ready after reset", man_ready, 1);
      manual_burst(4);
      run_init(0, 1'b0, 18'h0, 1'b0);
      manual_burst(3);
      run_init(1, 1'b1, 18'h0_1234, 1'b0);
      run_init(int'($urandom_range(3, 20)), 1'b0, 18'h0, 1'b1);
      abort_test(int'($urandom_range(4, 12)));
      run_init(int'($urandom_range(2, 30)), 1'b1, 18'h2_0ABC & 18'h1FFFF, 1'b1);
      @(negedge clk);
      init_reset = 1'b1;
      @(negedge clk);
      init_reset = 1'b0;
      check(!init_done && !mem_en, "R7 reset request from done", init_done, 0);
      manual_burst(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule